// File: doc/BRIEF.md
# Host Port Reset and Suspend Controller

This block holds the per-port control state that sits behind a host controller's port status and control word. It covers four bits: port reset, port enable, suspend and force-resume. Software changes them through a single-cycle write strobe that carries a bit mask and a data word, and it reads the live values back on a parallel bus. Line signalling, speed detection and resume sensing are done elsewhere. Speed detection and resume sensing arrive here as plain inputs.

A bus reset is a timed sequence. Software starts it by setting the reset bit and asks for it to end by clearing that bit. The reset bit keeps reading 1 until a minimum of `RESET_CYCLES` cycles has elapsed since the start and termination has been requested. When the reset ends, the port is enabled automatically if the attached device was reported as high speed. A suspend request waits for any transaction in flight to finish. While the port is suspended, downstream traffic is gated off. Suspend can be left only through a force-resume release or a new bus reset.

Top module: `hpr_port_ctl`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0, `port_state` is 2'b00 (disabled), and `downstream_allow` and `reset_done` are 0.
- R2: Register bit positions on `wr_mask`, `wr_data` and `rd_data` are: bit0 enable, bit1 suspend, bit2 force-resume, bit3 port reset. A write with mask bit3 and data bit3 set, made while the reset bit reads 0 and `hc_halted` is 0, makes the reset bit read 1 at the next edge. The same edge clears the enable, suspend and force-resume bits and drops any pending suspend.
- R3: A write of 0 to bit3 while the reset bit reads 1 only latches a termination request. The reset bit keeps reading 1 until the first edge at which a request is latched and at least `RESET_CYCLES` cycles have passed since the start. At that edge the reset bit reads 0, and `reset_done` is high for exactly that one following cycle.
- R4: Once termination is latched, and counting only cycles with `hc_halted` low, the reset completes within `RESET_CYCLES` cycles. When the request arrives after the minimum time, the reset completes one cycle after the write.
- R5: While `hc_halted` is 1, writes to bit3 are ignored and a running reset is held, so the reset bit does not change.
- R6: At reset completion, the enable bit takes the value of `hs_device`.
- R7: Writing 0 to bit0 clears the enable bit. Writing 1 to bit0 is ignored. The only way to set the enable bit is a completed reset.
- R8: A write of 1 to bit1 while enabled and idle (`xfer_active` low) sets suspend at the next edge. If `xfer_active` is high, suspend still reads 0 and takes effect at the edge that ends the first cycle with `xfer_active` low. If the enable bit is 0, the write is ignored.
- R9: Writes of 0 to bit1 are ignored. Suspend clears only when software writes 0 to bit2 while bit2 reads 1, or when a bus reset starts.
- R10: Force-resume is set by writing 1 to bit2 while suspended, or by `resume_detect` while suspended. A write of 1 to bit2 while not suspended is ignored. A write of 0 clears it.
- R11: `port_state` is 2'b00 when enable is 0, 2'b10 when enable is 1 and suspend is 1, and 2'b01 when enable is 1 and suspend is 0. `downstream_allow` is 1 only in state 2'b01 with the reset bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_mask | input | 4 | Bits affected by this write |
| wr_data | input | 4 | Values written to masked bits |
| hc_halted | input | 1 | Controller halted; blocks reset-bit writes and holds a running reset |
| hs_device | input | 1 | Attached device reported as high speed |
| xfer_active | input | 1 | A downstream transaction is in progress |
| resume_detect | input | 1 | Resume signalling seen on the port |
| rd_data | output | 4 | Current bit values, same layout as writes |
| port_state | output | 2 | Decoded state: disabled, enabled or suspended |
| downstream_allow | output | 1 | Downstream traffic may be forwarded |
| reset_done | output | 1 | One-cycle pulse as the reset bit first reads 0 |

## Verification
The bench builds the block with `RESET_CYCLES` set to 6, so a full minimum-length reset takes only a handful of cycles. This keeps every timing case short: an early termination request that must wait for the minimum, a late request that completes one cycle after the write, and a reset held across a halted stretch. With that value, the exact completion cycle is checked against hand-counted numbers as well as against the per-cycle model.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
    localparam int CTRL_W    = 4;
    localparam int BIT_PED   = 0;
    localparam int BIT_SUSP  = 1;
    localparam int BIT_FPR   = 2;
    localparam int BIT_PR    = 3;

    typedef enum logic [1:0] {
        PS_DISABLED  = 2'b00,
        PS_ENABLED   = 2'b01,
        PS_SUSPENDED = 2'b10
    } port_state_e;
endpackage

// File: rtl/hpr_reset_seq.sv
module hpr_reset_seq #(
    parameter int RESET_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pr_wr_en,
    input  logic pr_wr_val,
    input  logic hc_halted,
    output logic pr_o,
    output logic start_o,
    output logic done_o
);
    localparam int CW = $clog2(RESET_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RESET_CYCLES);

    typedef struct packed {
        logic          pr;
        logic          term;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        start_o = 1'b0;
        done_o  = 1'b0;
        // minimum-time counter, saturating at the limit
        if (seq_q.pr && seq_q.cnt != LIMIT) begin
            seq_d.cnt = seq_q.cnt + CW'(1);
        end
        // completion: request latched, minimum elapsed, controller running
        if (seq_q.pr && seq_q.term && seq_q.cnt == LIMIT && !hc_halted) begin
            done_o     = 1'b1;
            seq_d.pr   = 1'b0;
            seq_d.term = 1'b0;
            seq_d.cnt  = '0;
        end
        if (pr_wr_en && !hc_halted) begin
            if (pr_wr_val && !seq_q.pr) begin
                start_o    = 1'b1;
                seq_d.pr   = 1'b1;
                seq_d.term = 1'b0;
                seq_d.cnt  = '0;
            end else if (!pr_wr_val && seq_q.pr && !done_o) begin
                seq_d.term = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pr_o = seq_q.pr;

    // termination latency monitor (cycles with request latched, not halted)
    logic [CW:0] wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !seq_q.pr || !seq_q.term) begin
            wait_q <= '0;
        end else if (!hc_halted) begin
            wait_q <= wait_q + (CW+1)'(1);
        end
    end

    a_r4_term_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.pr && seq_q.term) |-> (wait_q < (CW+1)'(RESET_CYCLES)));

    a_r3_hold_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.pr && !seq_q.term) |=> seq_q.pr);

    a_r5_halt_freezes_pr: assert property (@(posedge clk) disable iff (!rst_n)
        hc_halted |=> (seq_q.pr == $past(seq_q.pr)));
endmodule

// File: rtl/hpr_susp_ctl.sv
module hpr_susp_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ped_i,
    input  logic ped_clr_i,
    input  logic start_i,
    input  logic susp_set_i,
    input  logic fpr_wr_en,
    input  logic fpr_wr_val,
    input  logic xfer_active,
    input  logic resume_detect,
    output logic susp_o,
    output logic fpr_o
);
    typedef struct packed {
        logic susp;
        logic pend;
        logic fpr;
    } susp_t;

    susp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // deferred entry once the bus goes idle
        if (st_q.pend && !xfer_active && !ped_clr_i) begin
            st_d.susp = 1'b1;
            st_d.pend = 1'b0;
        end
        // new request, only on an enabled port
        if (susp_set_i && ped_i && !ped_clr_i && !st_q.susp && !st_q.pend) begin
            if (xfer_active) begin
                st_d.pend = 1'b1;
            end else begin
                st_d.susp = 1'b1;
            end
        end
        if (st_q.susp && resume_detect) begin
            st_d.fpr = 1'b1;
        end
        if (fpr_wr_en) begin
            if (fpr_wr_val) begin
                if (st_q.susp) begin
                    st_d.fpr = 1'b1;
                end
            end else if (st_q.fpr) begin
                st_d.fpr  = 1'b0;
                st_d.susp = 1'b0;
                st_d.pend = 1'b0;
            end
        end
        if (ped_clr_i) begin
            st_d.pend = 1'b0;
        end
        if (start_i) begin
            st_d.susp = 1'b0;
            st_d.fpr  = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign susp_o = st_q.susp;
    assign fpr_o  = st_q.fpr;

    a_r8_entry_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.susp) |-> $past(!xfer_active));

    a_r9_exit_paths: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.susp) |-> ($fell(st_q.fpr) || $past(start_i)));

    a_r10_fpr_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fpr) |-> $past(st_q.susp));
endmodule

// File: rtl/hpr_port_ctl.sv
module hpr_port_ctl
    import hpr_pkg::*;
#(
    parameter int RESET_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_mask,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              hc_halted,
    input  logic              hs_device,
    input  logic              xfer_active,
    input  logic              resume_detect,
    output logic [CTRL_W-1:0] rd_data,
    output logic [1:0]        port_state,
    output logic              downstream_allow,
    output logic              reset_done
);
    typedef struct packed {
        logic ped;
        logic done;
    } top_t;

    top_t top_d, top_q;

    logic pr_q, seq_start, seq_done;
    logic susp_q, fpr_q;
    logic ped_clr, susp_set;
    port_state_e state;

    assign ped_clr  = wr_en && wr_mask[BIT_PED]  && !wr_data[BIT_PED];
    assign susp_set = wr_en && wr_mask[BIT_SUSP] &&  wr_data[BIT_SUSP];

    hpr_reset_seq #(
        .RESET_CYCLES(RESET_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pr_wr_en  (wr_en && wr_mask[BIT_PR]),
        .pr_wr_val (wr_data[BIT_PR]),
        .hc_halted (hc_halted),
        .pr_o      (pr_q),
        .start_o   (seq_start),
        .done_o    (seq_done)
    );

    hpr_susp_ctl u_susp (
        .clk           (clk),
        .rst_n         (rst_n),
        .ped_i         (top_q.ped),
        .ped_clr_i     (ped_clr),
        .start_i       (seq_start),
        .susp_set_i    (susp_set),
        .fpr_wr_en     (wr_en && wr_mask[BIT_FPR]),
        .fpr_wr_val    (wr_data[BIT_FPR]),
        .xfer_active   (xfer_active),
        .resume_detect (resume_detect),
        .susp_o        (susp_q),
        .fpr_o         (fpr_q)
    );

    always_comb begin
        top_d      = top_q;
        top_d.done = seq_done;
        if (ped_clr) begin
            top_d.ped = 1'b0;
        end
        if (seq_done) begin
            top_d.ped = hs_device;
        end
        if (seq_start) begin
            top_d.ped = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        if (!top_q.ped) begin
            state = PS_DISABLED;
        end else if (susp_q) begin
            state = PS_SUSPENDED;
        end else begin
            state = PS_ENABLED;
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_PED]  = top_q.ped;
        rd_data[BIT_SUSP] = susp_q;
        rd_data[BIT_FPR]  = fpr_q;
        rd_data[BIT_PR]   = pr_q;
    end

    assign port_state       = state;
    assign downstream_allow = (state == PS_ENABLED) && !pr_q;
    assign reset_done       = top_q.done;

    a_r2_start_disables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_q) |-> !top_q.ped);

    a_r6_enable_follows_speed: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.done |-> (top_q.ped == $past(hs_device)));

    a_r7_enable_only_by_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_q.ped) |-> top_q.done);

    a_r11_gate_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        downstream_allow |-> (top_q.ped && !susp_q && !pr_q));

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.done |=> !top_q.done);
endmodule

// File: tb/tb_hpr_port_ctl.sv
module tb_hpr_port_ctl;
    localparam int RC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_mask = '0;
    logic [3:0] wr_data = '0;
    logic       hc_halted = 1'b0;
    logic       hs_device = 1'b0;
    logic       xfer_active = 1'b0;
    logic       resume_detect = 1'b0;
    logic [3:0] rd_data;
    logic [1:0] port_state;
    logic       downstream_allow;
    logic       reset_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    hpr_port_ctl #(.RESET_CYCLES(RC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .hc_halted(hc_halted), .hs_device(hs_device),
        .xfer_active(xfer_active), .resume_detect(resume_detect),
        .rd_data(rd_data), .port_state(port_state),
        .downstream_allow(downstream_allow), .reset_done(reset_done)
    );

    // behavioural reference model
    bit m_pr, m_term, m_ped, m_susp, m_fpr, m_pend, m_done;
    int m_elapsed;
    bit t_done, t_start, t_term, t_pclr, t_sset, t_rest;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pr = 0; m_term = 0; m_ped = 0; m_susp = 0; m_fpr = 0;
            m_pend = 0; m_done = 0; m_elapsed = 0;
        end else begin
            t_done  = m_pr && m_term && (m_elapsed >= RC) && !hc_halted;
            t_start = wr_en && wr_mask[3] && wr_data[3] && !m_pr && !hc_halted;
            t_term  = wr_en && wr_mask[3] && !wr_data[3] && m_pr && !hc_halted && !t_done;
            t_pclr  = wr_en && wr_mask[0] && !wr_data[0];
            t_sset  = wr_en && wr_mask[1] && wr_data[1];
            // suspend and resume bookkeeping, using current values
            t_rest = 0;
            if (m_pend && !xfer_active && !t_pclr) begin m_susp = 1; m_pend = 0; end
            else if (t_sset && m_ped && !t_pclr && !m_susp && !m_pend) begin
                if (xfer_active) m_pend = 1; else m_susp = 1;
            end
            if (wr_en && wr_mask[2] && !wr_data[2] && m_fpr) t_rest = 1;
            if (rd_data_susp_prev() && resume_detect) m_fpr = 1;
            if (wr_en && wr_mask[2] && wr_data[2] && rd_data_susp_prev()) m_fpr = 1;
            if (t_rest) begin m_fpr = 0; m_susp = 0; m_pend = 0; end
            if (t_pclr) begin m_pend = 0; m_ped = 0; end
            // reset sequence
            if (m_pr) m_elapsed = m_elapsed + 1;
            m_done = t_done;
            if (t_done) begin m_pr = 0; m_term = 0; m_ped = hs_device; end
            if (t_term) m_term = 1;
            if (t_start) begin
                m_pr = 1; m_term = 0; m_elapsed = 0; m_ped = 0;
                m_susp = 0; m_fpr = 0; m_pend = 0;
            end
        end
    end

    // suspend value visible before this edge (the model keeps it in a shadow)
    bit m_susp_prev;
    always @(negedge clk) m_susp_prev = m_susp;
    function automatic bit rd_data_susp_prev();
        return m_susp_prev;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_state();
        if (!m_ped) return 0;
        if (m_susp) return 2;
        return 1;
    endfunction

    always @(negedge clk) begin
        if (model_on) begin
            chk("R3 model reset bit",     rd_data[3], m_pr);
            chk("R7 model enable bit",    rd_data[0], m_ped);
            chk("R9 model suspend bit",   rd_data[1], m_susp);
            chk("R10 model resume bit",   rd_data[2], m_fpr);
            chk("R3 model done pulse",    reset_done, m_done);
            chk("R11 model port state",   port_state, exp_state());
            chk("R11 model allow",        downstream_allow, m_ped && !m_susp && !m_pr);
        end
    end

    task automatic wr(input logic [3:0] m, input logic [3:0] d);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pr_low(output int k);
        k = 0;
        while (rd_data[3] && k < 50) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 state after reset", port_state, 0);
        chk("R1 allow after reset", downstream_allow, 0);

        // early termination request waits for the minimum
        hs_device = 1'b1;
        wr(4'b1000, 4'b1000);
        chk("R2 reset bit set", rd_data[3], 1);
        chk("R2 enable cleared", rd_data[0], 0);
        wr(4'b1000, 4'b0000);
        chk("R3 still reads 1 after clear", rd_data[3], 1);
        wait_pr_low(k);
        chk("R3 R4 cycles to completion", k, RC);
        chk("R3 done pulse", reset_done, 1);
        chk("R6 enabled for high speed", rd_data[0], 1);
        chk("R11 enabled state", port_state, 1);
        chk("R11 allow when enabled", downstream_allow, 1);
        @(negedge clk);
        chk("R3 done pulse one cycle", reset_done, 0);

        // late termination completes one cycle after the write
        hs_device = 1'b0;
        wr(4'b1000, 4'b1000);
        chk("R11 allow off in reset", downstream_allow, 0);
        idle(RC + 4);
        chk("R3 held without request", rd_data[3], 1);
        wr(4'b1000, 4'b0000);
        wait_pr_low(k);
        chk("R4 late request latency", k, 1);
        chk("R6 not enabled for full speed", rd_data[0], 0);

        // halted controller
        hc_halted = 1'b1;
        wr(4'b1000, 4'b1000);
        chk("R5 start ignored while halted", rd_data[3], 0);
        hc_halted = 1'b0;
        hs_device = 1'b1;
        wr(4'b1000, 4'b1000);
        hc_halted = 1'b1;
        idle(RC + 2);
        wr(4'b1000, 4'b0000);
        idle(3);
        chk("R5 clear ignored while halted", rd_data[3], 1);
        hc_halted = 1'b0;
        wr(4'b1000, 4'b0000);
        wait_pr_low(k);
        chk("R5 completes after halt lifts", k, 1);
        chk("R6 enabled after halted reset", rd_data[0], 1);

        // enable bit writes
        wr(4'b0001, 4'b0000);
        chk("R7 enable cleared by write 0", rd_data[0], 0);
        wr(4'b0001, 4'b0001);
        chk("R7 enable write 1 ignored", rd_data[0], 0);
        wr(4'b0010, 4'b0010);
        chk("R8 suspend ignored when disabled", rd_data[1], 0);
        wr(4'b1000, 4'b1000);
        wr(4'b1000, 4'b0000);
        wait_pr_low(k);
        chk("R6 re-enabled", rd_data[0], 1);

        // immediate suspend, resume and release
        wr(4'b0100, 4'b0100);
        chk("R10 resume write ignored when not suspended", rd_data[2], 0);
        wr(4'b0010, 4'b0010);
        chk("R8 suspend when idle", rd_data[1], 1);
        chk("R11 suspended state", port_state, 2);
        chk("R11 allow off when suspended", downstream_allow, 0);
        wr(4'b0010, 4'b0000);
        chk("R9 suspend write 0 ignored", rd_data[1], 1);
        resume_detect = 1'b1;
        @(negedge clk);
        resume_detect = 1'b0;
        chk("R10 resume detect sets bit", rd_data[2], 1);
        wr(4'b0100, 4'b0000);
        chk("R9 release clears suspend", rd_data[1], 0);
        chk("R10 release clears resume bit", rd_data[2], 0);
        chk("R11 back to enabled", port_state, 1);

        // suspend deferred behind a transaction
        xfer_active = 1'b1;
        wr(4'b0010, 4'b0010);
        idle(2);
        chk("R8 suspend deferred", rd_data[1], 0);
        chk("R8 traffic still allowed", downstream_allow, 1);
        xfer_active = 1'b0;
        @(negedge clk);
        chk("R8 suspend after transaction", rd_data[1], 1);

        // software resume write and reset exit from suspend
        wr(4'b0100, 4'b0100);
        chk("R10 resume write while suspended", rd_data[2], 1);
        wr(4'b1000, 4'b1000);
        chk("R9 reset start clears suspend", rd_data[1], 0);
        chk("R2 reset start clears resume bit", rd_data[2], 0);
        wr(4'b1000, 4'b0000);
        wait_pr_low(k);
        chk("R4 completion after suspend", k, RC);

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule